// File: doc/BRIEF.md
# Interrupt Priority Level Resolver

This block looks at every interrupt request that is pending in a processor core and works out the single interrupt priority level (IPL) that should be serviced. Software requests sit in a programmable request register. Each set bit maps to a small level that counts up from 1 at the bottom of its bit field. External interrupt lines map to higher levels equal to the bit position they occupy in the summary word. The winning level is compared against the current IPL register. If it is strictly higher, the block raises a one-cycle trap strobe. On that same clock edge it captures a summary mask of all pending requests and the winning level.

The core writes the IPL register and the software-request register through simple write-enable ports. Both registers drop the bits they do not implement. A separate asynchronous-trap request vector is not serviced. When it is nonzero, an error flag is raised one cycle later.

Top module: `ipl_resolver`

## Requirements
- R1: After a synchronous active-low reset, the trap strobe, summary, interrupt ID, IPL register, software-request register and error flag all read zero.
- R2: A software request at bit i (4 to 18) resolves to level i−3 and sets summary bit i.
- R3: External line k (0 to 3) resolves to level 20+k and sets summary bit 20+k. Summary bit 19 and bits 0 to 3 always read zero.
- R4: When several requests are pending, the highest level wins. The summary holds every pending request from both sources.
- R5: A trap is raised only when the resolved level is nonzero and strictly greater than the IPL register. A level equal to the IPL raises no trap.
- R6: The summary and ID registers are written on the same edge that sets the trap strobe. At any other time they hold their value.
- R7: The trap strobe lasts one cycle. While the trap condition persists, the strobe repeats every second cycle.
- R8: A write to the IPL register keeps only data bits 4:0. The new value takes effect one cycle after the write.
- R9: A write to the software-request register keeps only the bits under mask 0x7fff0, which is bits 18:4.
- R10: A nonzero asynchronous-trap request sets the error flag one cycle later. A zero request clears it one cycle later.
- R11: With nothing pending, no trap is raised and the summary and ID do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ipl_wr_en | input | 1 | Write strobe for the IPL register |
| ipl_wr_data | input | 32 | IPL write data; bits 4:0 kept |
| sw_wr_en | input | 1 | Write strobe for the software-request register |
| sw_wr_data | input | 32 | Software-request write data; bits 18:4 kept |
| ext_irq | input | 4 | External interrupt lines, bit k maps to level 20+k |
| async_req | input | 4 | Asynchronous-trap request vector (unsupported) |
| trap_o | output | 1 | One-cycle interrupt trap strobe |
| isum_o | output | 24 | Captured interrupt summary mask |
| iid_o | output | 5 | Captured winning level |
| ipl_o | output | 5 | Current IPL register |
| swreq_o | output | 19 | Software-request register at its bit positions |
| async_err_o | output | 1 | Unsupported asynchronous-trap flag |

## Verification
The bench sweeps all 32 IPL values against a set of mixed software and external patterns. Junk is written into the unused write bits. The equal-level boundary catches a design that uses greater-or-equal, because that design traps one level too early. Overlapping software and external requests expose a design that picks the first set bit instead of the last, which reports too low an ID. An off-by-one in the software renumbering shows up as a shifted ID. A held trap condition detects a design whose strobe stays high, and a design that writes the summary without a trap is seen as a changed register on an idle case.

// File: rtl/ipl_pkg.sv
// ipl_pkg: shared widths and default bit ranges for the IPL resolver.
// Assumes the software field lies wholly below the external field.
package ipl_pkg;
    localparam int IPL_W      = 5;
    localparam int DATA_W     = 32;
    localparam int DEF_SW_LO  = 4;
    localparam int DEF_SW_HI  = 19;   // exclusive
    localparam int DEF_EXT_LO = 20;
    localparam int DEF_EXT_HI = 24;   // exclusive
    localparam int ASYNC_W    = 4;
    typedef logic [IPL_W-1:0] ipl_t;
endpackage

// File: rtl/ipl_level_scan.sv
// ipl_level_scan: priority scan of a request vector.
// Bit k maps to level LVL_BASE+k; the highest set bit wins.
// Assumes LVL_BASE+N-1 fits in IPL_W bits.
module ipl_level_scan
    import ipl_pkg::*;
#(
    parameter int N        = 15,
    parameter int LVL_BASE = 1
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output ipl_t         level
);
    // Ascending scan: a later (higher) set bit overrides earlier ones.
    always_comb begin
        hit   = 1'b0;
        level = '0;
        for (int k = 0; k < N; k++) begin
            if (req[k]) begin
                hit   = 1'b1;
                level = ipl_t'(LVL_BASE + k);
            end
        end
    end
endmodule

// File: rtl/ipl_capture.sv
// ipl_capture: compares the resolved level against the current IPL and
// captures summary and ID with a one-cycle trap strobe.
// Assumes level == 0 means nothing is pending.
module ipl_capture
    import ipl_pkg::*;
#(
    parameter int SUM_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ipl_t             ipl_cur,
    input  ipl_t             level,
    input  logic [SUM_W-1:0] summary,
    output logic             trap_q,
    output logic [SUM_W-1:0] sum_q,
    output ipl_t             id_q
);
    logic take;

    // Trap decision: strictly above current IPL, one idle cycle between strobes.
    always_comb take = (level != '0) && (level > ipl_cur) && !trap_q;

    // Capture of strobe, summary and ID on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q <= 1'b0;
            sum_q  <= '0;
            id_q   <= '0;
        end else begin
            trap_q <= take;
            if (take) begin
                sum_q <= summary;
                id_q  <= level;
            end
        end
    end

    a_r5_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> (id_q > $past(ipl_cur)));
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |=> !trap_q);
    a_r6_hold_without_trap: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_q |-> ($stable(sum_q) && $stable(id_q)));
    a_r11_idle_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |=> !trap_q);
endmodule

// File: rtl/ipl_resolver.sv
// ipl_resolver: holds the IPL and software-request registers, scans
// software and external requests, and drives the trap capture.
// Assumes SW_HI <= EXT_LO and EXT_HI <= 32.
module ipl_resolver
    import ipl_pkg::*;
#(
    parameter int SW_LO  = DEF_SW_LO,
    parameter int SW_HI  = DEF_SW_HI,
    parameter int EXT_LO = DEF_EXT_LO,
    parameter int EXT_HI = DEF_EXT_HI
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ipl_wr_en,
    input  logic [DATA_W-1:0]        ipl_wr_data,
    input  logic                     sw_wr_en,
    input  logic [DATA_W-1:0]        sw_wr_data,
    input  logic [EXT_HI-EXT_LO-1:0] ext_irq,
    input  logic [ASYNC_W-1:0]       async_req,
    output logic                     trap_o,
    output logic [EXT_HI-1:0]        isum_o,
    output logic [IPL_W-1:0]         iid_o,
    output logic [IPL_W-1:0]         ipl_o,
    output logic [SW_HI-1:0]         swreq_o,
    output logic                     async_err_o
);
    localparam int SW_N  = SW_HI - SW_LO;
    localparam int EXT_N = EXT_HI - EXT_LO;
    localparam int SUM_W = EXT_HI;

    ipl_t             ipl_q;
    logic [SW_N-1:0]  sw_q;
    logic             sw_hit, ext_hit;
    ipl_t             sw_lvl, ext_lvl, best_lvl;
    logic [SUM_W-1:0] sum_vec;
    ipl_t             id_w;

    // IPL register: keeps only the low IPL_W bits of the write data.
    always_ff @(posedge clk) begin
        if (!rst_n)         ipl_q <= '0;
        else if (ipl_wr_en) ipl_q <= ipl_wr_data[IPL_W-1:0];
    end

    // Software-request register: keeps only the implemented field.
    always_ff @(posedge clk) begin
        if (!rst_n)        sw_q <= '0;
        else if (sw_wr_en) sw_q <= sw_wr_data[SW_HI-1:SW_LO];
    end

    // Error flag for the unsupported asynchronous-trap request.
    always_ff @(posedge clk) begin
        if (!rst_n) async_err_o <= 1'b0;
        else        async_err_o <= |async_req;
    end

    ipl_level_scan #(.N(SW_N), .LVL_BASE(1)) u_sw_scan (
        .req(sw_q), .hit(sw_hit), .level(sw_lvl));

    ipl_level_scan #(.N(EXT_N), .LVL_BASE(EXT_LO)) u_ext_scan (
        .req(ext_irq), .hit(ext_hit), .level(ext_lvl));

    // Merge: external level overrides software level when higher.
    always_comb begin
        best_lvl = sw_hit ? sw_lvl : '0;
        if (ext_hit && (ext_lvl > best_lvl)) best_lvl = ext_lvl;
    end

    // Summary: every pending request at its own bit position.
    always_comb begin
        sum_vec = '0;
        sum_vec[SW_HI-1:SW_LO]   = sw_q;
        sum_vec[EXT_HI-1:EXT_LO] = ext_irq;
    end

    ipl_capture #(.SUM_W(SUM_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .ipl_cur(ipl_q), .level(best_lvl),
        .summary(sum_vec), .trap_q(trap_o), .sum_q(isum_o), .id_q(id_w));

    // Output wiring of register contents.
    always_comb begin
        iid_o   = id_w;
        ipl_o   = ipl_q;
        swreq_o = '0;
        swreq_o[SW_HI-1:SW_LO] = sw_q;
    end

    a_r8_ipl_write_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ipl_wr_en) |-> (ipl_o == $past(ipl_wr_data[IPL_W-1:0])));
    a_r10_async_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        $past(|async_req) |-> async_err_o);
endmodule

// File: tb/ipl_resolver_tb.sv
module ipl_resolver_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ipl_wr_en = 1'b0;
    logic [31:0] ipl_wr_data = '0;
    logic        sw_wr_en = 1'b0;
    logic [31:0] sw_wr_data = '0;
    logic [3:0]  ext_irq = '0;
    logic [3:0]  async_req = '0;
    logic        trap_o;
    logic [23:0] isum_o;
    logic [4:0]  iid_o, ipl_o;
    logic [18:0] swreq_o;
    logic        async_err_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [23:0] exp_sum = '0;
    logic [4:0]  exp_id = '0;
    bit done = 0;

    always #5 clk = ~clk;

    ipl_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .ipl_wr_en(ipl_wr_en), .ipl_wr_data(ipl_wr_data),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .ext_irq(ext_irq),
        .async_req(async_req), .trap_o(trap_o), .isum_o(isum_o), .iid_o(iid_o),
        .ipl_o(ipl_o), .swreq_o(swreq_o), .async_err_o(async_err_o));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick_sample();
        @(posedge clk);
        #1;
    endtask

    // One case: block with IPL 31, load software, then the real IPL.
    task automatic run_case(input logic [31:0] sw_raw, input logic [3:0] ext_v,
                            input logic [31:0] ipl_raw);
        logic [31:0] swm;
        logic [4:0]  lvl;
        logic [23:0] sum;
        logic        fire;
        @(negedge clk);
        ipl_wr_en = 1; ipl_wr_data = 32'd31; sw_wr_en = 1; sw_wr_data = '0; ext_irq = '0;
        @(negedge clk);
        ipl_wr_en = 0; sw_wr_data = sw_raw; ext_irq = ext_v;
        tick_sample();
        swm = sw_raw & 32'h0007_fff0;
        chk("R9 sw mask", {13'd0, swreq_o}, swm);
        @(negedge clk);
        sw_wr_en = 0; ipl_wr_en = 1; ipl_wr_data = ipl_raw;
        tick_sample();
        chk("R8 ipl low bits", {27'd0, ipl_o}, {27'd0, ipl_raw[4:0]});
        chk("R11 blocked/idle no trap", {31'd0, trap_o}, 32'd0);
        @(negedge clk);
        ipl_wr_en = 0;
        lvl = '0;
        for (int i = 4; i <= 18; i++) if (swm[i]) lvl = 5'(i - 3);
        for (int k = 0; k < 4; k++) if (ext_v[k] && (5'(20 + k) > lvl)) lvl = 5'(20 + k);
        sum = swm[23:0] | ({20'd0, ext_v} << 20);
        fire = (lvl != 0) && (lvl > ipl_raw[4:0]);
        if (fire) begin exp_sum = sum; exp_id = lvl; end
        tick_sample();
        chk("R5 trap decision", {31'd0, trap_o}, {31'd0, fire});
        chk("R2 R3 R4 R6 summary", {8'd0, isum_o}, {8'd0, exp_sum});
        chk("R2 R3 R4 R6 id", {27'd0, iid_o}, {27'd0, exp_id});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 trap", {31'd0, trap_o}, 0);
        chk("R1 sum", {8'd0, isum_o}, 0);
        chk("R1 id", {27'd0, iid_o}, 0);
        chk("R1 ipl", {27'd0, ipl_o}, 0);
        chk("R1 sw", {13'd0, swreq_o}, 0);
        chk("R1 err", {31'd0, async_err_o}, 0);
        @(negedge clk); rst_n = 1;

        // R2 single software bits at every level boundary
        for (int i = 4; i <= 18; i++) begin
            run_case(32'd1 << i, 4'd0, 32'd0 | (i - 3 - 1));  // just below
            run_case(32'd1 << i, 4'd0, 32'd0 | (i - 3));      // equal: R5 no trap
        end
        // R3 single external lines
        for (int k = 0; k < 4; k++) begin
            run_case(32'd0, 4'd1 << k, 32'd19 + k);
            run_case(32'd0, 4'd1 << k, 32'd20 + k);
        end
        // R4 mixed patterns swept across all IPL values, junk in unused bits
        for (int p = 0; p < 24; p++) begin
            logic [31:0] swr;
            logic [3:0]  ev;
            swr = (p % 4 == 1) ? 32'hFFF8_000F : (32'(p) * 32'h0002_4925) ^ 32'hA008_000B;
            ev  = (p % 3 == 0) ? 4'd0 : 4'((p * 7) & 15);
            if (p == 0) swr = 32'hFFF8_000F;   // R11 nothing pending after mask
            for (int ip = 0; ip < 32; ip++)
                run_case(swr, ev, (32'hDEAD_BE00 ^ 32'(p << 8)) & ~32'h1F | 32'(ip));
        end

        // R7 held condition: strobe repeats every second cycle
        run_case(32'h10, 4'd0, 32'd0);
        tick_sample(); chk("R7 pulse low", {31'd0, trap_o}, 0);
        tick_sample(); chk("R7 pulse again", {31'd0, trap_o}, 1);
        tick_sample(); chk("R7 pulse low again", {31'd0, trap_o}, 0);

        // R10 asynchronous request flag
        @(negedge clk); async_req = 4'b0100;
        tick_sample(); chk("R10 err set", {31'd0, async_err_o}, 1);
        @(negedge clk); async_req = 4'b0000;
        tick_sample(); chk("R10 err clear", {31'd0, async_err_o}, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule